// File: doc/BRIEF.md
# Interrupt Context Save/Restore Unit

This unit keeps the processor context needed to come back from an interrupt. It has two separate save levels, one for ordinary (non-critical) interrupts and one for critical interrupts. Each level is a pair of 32-bit registers: one holds the resume address and one holds a copy of the machine state register. When the interrupt logic takes an interrupt of a given class, the unit captures the current resume address and machine state into that class's pair. On the matching return instruction, it issues a fetch redirect to the saved address and a load of the saved state into the machine state register.

Software can read and write all four save registers through a special-purpose register (SPR) port. The non-critical pair sits at SPR numbers 26 (address) and 27 (state). The critical pair sits at numbers set by parameters, 58 and 59 by default. A synchronous reset clears the unit's outputs but leaves the save registers as they were. The save registers have no power-on value.

Top module: `intr_ctx_unit`

## Requirements
- R1: When `int_nc_i` is 1 at a clock edge, the non-critical address register takes `resume_pc_i` and the non-critical state register takes all 32 bits of `msr_cur_i`.
- R2: When `int_crit_i` is 1 at a clock edge, the critical address and state registers capture `resume_pc_i` and `msr_cur_i` in the same way. Both classes may capture in the same cycle.
- R3: The code `ret_kind_i` = 1 is a non-critical return. After the edge that samples it, `redir_vld_o` and `msr_ld_o` are 1 for one cycle. In that cycle `redir_pc_o` is the non-critical address and `msr_ld_data_o` is the full non-critical state, reserved bits included.
- R4: The code `ret_kind_i` = 2 is a critical return. It behaves the same way, using the critical pair.
- R5: The codes `ret_kind_i` = 0 (none) and 3 (debug return) produce no redirect and no state load. In any cycle without a valid redirect, `redir_pc_o` and `msr_ld_data_o` are 0.
- R6: A return of any kind never changes a save register. Only a capture or an SPR write changes one.
- R7: An SPR write (`spr_wr_i`) to 26, 27, 58 or 59 loads `spr_wdata_i` into that register. A write to a state register (27 or 59) clears the bits set in parameter `RSV_MASK`.
- R8: An SPR read is registered. One cycle after `spr_rd_i`, `spr_rdata_o` shows the register value from before that edge. A read of any other number returns 0 with `spr_miss_o` = 1. With no read, both outputs are 0.
- R9: If a capture and an SPR write hit the same register in the same cycle, the register takes the captured value.
- R10: While `rst` is 1, all outputs are 0 on the next edge. The four save registers keep their contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (not power-on) |
| int_nc_i | input | 1 | Non-critical interrupt taken this cycle |
| int_crit_i | input | 1 | Critical interrupt taken this cycle |
| resume_pc_i | input | 32 | Address at which to resume the interrupted process |
| msr_cur_i | input | 32 | Current machine state register |
| ret_kind_i | input | 2 | Return executed: 0 none, 1 non-critical, 2 critical, 3 debug |
| spr_wr_i | input | 1 | SPR write strobe |
| spr_rd_i | input | 1 | SPR read strobe |
| spr_num_i | input | 10 | SPR number |
| spr_wdata_i | input | 32 | SPR write data |
| spr_rdata_o | output | 32 | Registered SPR read data |
| spr_miss_o | output | 1 | Read addressed a number this unit does not hold |
| redir_vld_o | output | 1 | One-cycle fetch redirect pulse |
| redir_pc_o | output | 32 | Redirect target address |
| msr_ld_o | output | 1 | Load machine state register this cycle |
| msr_ld_data_o | output | 32 | State to load |

## Verification
All results are due one clock after the edge that samples their stimulus. Save registers change at that edge. Redirect, state load and read data appear as registered outputs directly after it. A read issued in the cycle after a capture, write or return therefore sees the new register contents. The bench drives inputs on the falling edge and keeps a behavioural model that it updates on the rising edge. On every following falling edge it compares each output against the model. Directed checks sample at that same falling edge.

// File: rtl/intr_ctx_pkg.sv
package intr_ctx_pkg;

  typedef enum logic [1:0] {
    RET_NONE = 2'd0,
    RET_NC   = 2'd1,
    RET_CRIT = 2'd2,
    RET_DBG  = 2'd3
  } ret_kind_e;

  localparam int NUM_CLASSES = 2;
  localparam int CLS_NC      = 0;
  localparam int CLS_CRIT    = 1;

endpackage

// File: rtl/ctx_save_pair.sv
module ctx_save_pair #(
  parameter int          XLEN      = 32,
  parameter int          SPRW      = 10,
  parameter int          ADDR_NUM  = 26,
  parameter int          STATE_NUM = 27,
  parameter logic [31:0] RSV_MASK  = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_i,
  input  logic [XLEN-1:0] cap_pc_i,
  input  logic [XLEN-1:0] cap_msr_i,
  input  logic            spr_wr_i,
  input  logic [SPRW-1:0] spr_num_i,
  input  logic [XLEN-1:0] spr_wdata_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] state_o
);

  localparam logic [SPRW-1:0] A_NUM = SPRW'(ADDR_NUM);
  localparam logic [SPRW-1:0] S_NUM = SPRW'(STATE_NUM);
  localparam logic [XLEN-1:0] KEEP  = ~XLEN'(RSV_MASK);

  logic            wr_addr, wr_state;
  logic [XLEN-1:0] addr_q, state_q;

  assign wr_addr  = spr_wr_i && (spr_num_i == A_NUM);
  assign wr_state = spr_wr_i && (spr_num_i == S_NUM);

  // no reset: contents survive the synchronous reset
  always_ff @(posedge clk) begin
    if (cap_i) begin
      addr_q  <= cap_pc_i;
      state_q <= cap_msr_i;
    end else begin
      if (wr_addr)  addr_q  <= spr_wdata_i;
      if (wr_state) state_q <= spr_wdata_i & KEEP;
    end
  end

  assign addr_o  = addr_q;
  assign state_o = state_q;

  // R1 R2 R9
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (addr_o == $past(cap_pc_i)) && (state_o == $past(cap_msr_i)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_i && !spr_wr_i) |=> ($stable(addr_o) && $stable(state_o)));

  // R7
  rsv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_i && wr_state) |=> ((state_o & XLEN'(RSV_MASK)) == '0));

endmodule

// File: rtl/ctx_return_sel.sv
module ctx_return_sel
  import intr_ctx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ret_kind_e       ret_i,
  input  logic [XLEN-1:0] nc_addr_i,
  input  logic [XLEN-1:0] nc_state_i,
  input  logic [XLEN-1:0] cr_addr_i,
  input  logic [XLEN-1:0] cr_state_i,
  output logic            redir_vld_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic            msr_ld_o,
  output logic [XLEN-1:0] msr_ld_data_o
);

  logic            take;
  logic [XLEN-1:0] sel_pc, sel_state;

  always_comb begin
    take      = 1'b0;
    sel_pc    = '0;
    sel_state = '0;
    unique case (ret_i)
      RET_NC: begin
        take      = 1'b1;
        sel_pc    = nc_addr_i;
        sel_state = nc_state_i;
      end
      RET_CRIT: begin
        take      = 1'b1;
        sel_pc    = cr_addr_i;
        sel_state = cr_state_i;
      end
      default: begin
        take      = 1'b0;
        sel_pc    = '0;
        sel_state = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_vld_o   <= 1'b0;
      redir_pc_o    <= '0;
      msr_ld_o      <= 1'b0;
      msr_ld_data_o <= '0;
    end else begin
      redir_vld_o   <= take;
      redir_pc_o    <= sel_pc;
      msr_ld_o      <= take;
      msr_ld_data_o <= sel_state;
    end
  end

  // R3
  nc_redir_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i == RET_NC) |=> (redir_vld_o && redir_pc_o == $past(nc_addr_i)
                           && msr_ld_data_o == $past(nc_state_i)));

  // R4
  cr_redir_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i == RET_CRIT) |=> (redir_vld_o && redir_pc_o == $past(cr_addr_i)
                             && msr_ld_data_o == $past(cr_state_i)));

  // R5
  no_redir_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i == RET_NONE || ret_i == RET_DBG) |=> (!redir_vld_o && !msr_ld_o));

  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!redir_vld_o && !msr_ld_o && redir_pc_o == '0));

endmodule

// File: rtl/ctx_spr_read.sv
module ctx_spr_read #(
  parameter int XLEN      = 32,
  parameter int SPRW      = 10,
  parameter int NC_A_NUM  = 26,
  parameter int NC_S_NUM  = 27,
  parameter int CR_A_NUM  = 58,
  parameter int CR_S_NUM  = 59
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_i,
  input  logic [SPRW-1:0] num_i,
  input  logic [XLEN-1:0] nc_addr_i,
  input  logic [XLEN-1:0] nc_state_i,
  input  logic [XLEN-1:0] cr_addr_i,
  input  logic [XLEN-1:0] cr_state_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            miss_o
);

  logic [XLEN-1:0] mux_data;
  logic            mux_hit;

  always_comb begin
    mux_hit  = 1'b1;
    mux_data = '0;
    if      (num_i == SPRW'(NC_A_NUM)) mux_data = nc_addr_i;
    else if (num_i == SPRW'(NC_S_NUM)) mux_data = nc_state_i;
    else if (num_i == SPRW'(CR_A_NUM)) mux_data = cr_addr_i;
    else if (num_i == SPRW'(CR_S_NUM)) mux_data = cr_state_i;
    else                               mux_hit  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      miss_o  <= 1'b0;
    end else begin
      rdata_o <= rd_i ? mux_data : '0;
      miss_o  <= rd_i && !mux_hit;
    end
  end

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    miss_o |-> (rdata_o == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_o == '0 && !miss_o));

endmodule

// File: rtl/intr_ctx_unit.sv
module intr_ctx_unit
  import intr_ctx_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          SPRW      = 10,
  parameter int          NC_A_NUM  = 26,
  parameter int          NC_S_NUM  = 27,
  parameter int          CR_A_NUM  = 58,
  parameter int          CR_S_NUM  = 59,
  parameter logic [31:0] RSV_MASK  = 32'h0000_0F00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            int_nc_i,
  input  logic            int_crit_i,
  input  logic [XLEN-1:0] resume_pc_i,
  input  logic [XLEN-1:0] msr_cur_i,
  input  logic [1:0]      ret_kind_i,
  input  logic            spr_wr_i,
  input  logic            spr_rd_i,
  input  logic [SPRW-1:0] spr_num_i,
  input  logic [XLEN-1:0] spr_wdata_i,
  output logic [XLEN-1:0] spr_rdata_o,
  output logic            spr_miss_o,
  output logic            redir_vld_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic            msr_ld_o,
  output logic [XLEN-1:0] msr_ld_data_o
);

  logic [NUM_CLASSES-1:0] cap_vec;
  logic [XLEN-1:0]        sv_addr  [NUM_CLASSES];
  logic [XLEN-1:0]        sv_state [NUM_CLASSES];
  ret_kind_e              ret_kind;

  assign cap_vec  = {int_crit_i, int_nc_i};
  assign ret_kind = ret_kind_e'(ret_kind_i);

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_pair
    localparam int A_N = (g == CLS_NC) ? NC_A_NUM : CR_A_NUM;
    localparam int S_N = (g == CLS_NC) ? NC_S_NUM : CR_S_NUM;
    ctx_save_pair #(
      .XLEN(XLEN), .SPRW(SPRW), .ADDR_NUM(A_N), .STATE_NUM(S_N),
      .RSV_MASK(RSV_MASK)
    ) u_pair (
      .clk         (clk),
      .rst         (rst),
      .cap_i       (cap_vec[g]),
      .cap_pc_i    (resume_pc_i),
      .cap_msr_i   (msr_cur_i),
      .spr_wr_i    (spr_wr_i),
      .spr_num_i   (spr_num_i),
      .spr_wdata_i (spr_wdata_i),
      .addr_o      (sv_addr[g]),
      .state_o     (sv_state[g])
    );
  end

  ctx_return_sel #(.XLEN(XLEN)) u_ret (
    .clk           (clk),
    .rst           (rst),
    .ret_i         (ret_kind),
    .nc_addr_i     (sv_addr[CLS_NC]),
    .nc_state_i    (sv_state[CLS_NC]),
    .cr_addr_i     (sv_addr[CLS_CRIT]),
    .cr_state_i    (sv_state[CLS_CRIT]),
    .redir_vld_o   (redir_vld_o),
    .redir_pc_o    (redir_pc_o),
    .msr_ld_o      (msr_ld_o),
    .msr_ld_data_o (msr_ld_data_o)
  );

  ctx_spr_read #(
    .XLEN(XLEN), .SPRW(SPRW), .NC_A_NUM(NC_A_NUM), .NC_S_NUM(NC_S_NUM),
    .CR_A_NUM(CR_A_NUM), .CR_S_NUM(CR_S_NUM)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (spr_rd_i),
    .num_i      (spr_num_i),
    .nc_addr_i  (sv_addr[CLS_NC]),
    .nc_state_i (sv_state[CLS_NC]),
    .cr_addr_i  (sv_addr[CLS_CRIT]),
    .cr_state_i (sv_state[CLS_CRIT]),
    .rdata_o    (spr_rdata_o),
    .miss_o     (spr_miss_o)
  );

  // R3 R4
  pulse_ld_chk: assert property (@(posedge clk) disable iff (rst)
    redir_vld_o |-> msr_ld_o);

  // R6
  crit_ret_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_kind_i == 2'd2 && !int_nc_i && !spr_wr_i) |=>
      $stable(sv_addr[CLS_NC]));

endmodule

// File: tb/intr_ctx_unit_tb.sv
module intr_ctx_unit_tb;

  localparam logic [31:0] RSV = 32'h0000_0F00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_nc = 1'b0, int_crit = 1'b0;
  logic [31:0] resume_pc = '0, msr_cur = '0;
  logic [1:0]  ret_kind = 2'd0;
  logic        spr_wr = 1'b0, spr_rd = 1'b0;
  logic [9:0]  spr_num = '0;
  logic [31:0] spr_wdata = '0;
  logic [31:0] spr_rdata, redir_pc, msr_ld_data;
  logic        spr_miss, redir_vld, msr_ld;

  always #4 clk = ~clk;

  intr_ctx_unit #(.RSV_MASK(RSV)) u_dut (
    .clk(clk), .rst(rst), .int_nc_i(int_nc), .int_crit_i(int_crit),
    .resume_pc_i(resume_pc), .msr_cur_i(msr_cur), .ret_kind_i(ret_kind),
    .spr_wr_i(spr_wr), .spr_rd_i(spr_rd), .spr_num_i(spr_num),
    .spr_wdata_i(spr_wdata), .spr_rdata_o(spr_rdata), .spr_miss_o(spr_miss),
    .redir_vld_o(redir_vld), .redir_pc_o(redir_pc), .msr_ld_o(msr_ld),
    .msr_ld_data_o(msr_ld_data)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model: index 0 nc addr, 1 nc state, 2 crit addr, 3 crit state
  logic [31:0] m_reg [4] = '{default: '0};
  logic        e_vld = 0, e_ld = 0, e_miss = 0;
  logic [31:0] e_pc = 0, e_ldd = 0, e_rd = 0;
  string       e_tag = "R10";

  function automatic int idx_of(logic [9:0] n);
    case (n)
      10'd26: return 0;
      10'd27: return 1;
      10'd58: return 2;
      10'd59: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    int ix;
    if (rst) begin
      e_vld = 0; e_ld = 0; e_pc = 0; e_ldd = 0; e_rd = 0; e_miss = 0;
      e_tag = "R10";
    end else begin
      e_vld = (ret_kind == 2'd1) || (ret_kind == 2'd2);
      e_ld  = e_vld;
      e_pc  = (ret_kind == 2'd1) ? m_reg[0] : (ret_kind == 2'd2) ? m_reg[2] : 32'h0;
      e_ldd = (ret_kind == 2'd1) ? m_reg[1] : (ret_kind == 2'd2) ? m_reg[3] : 32'h0;
      e_tag = (ret_kind == 2'd1) ? "R3" : (ret_kind == 2'd2) ? "R4" : "R5";
      ix = idx_of(spr_num);
      e_rd   = (spr_rd && ix >= 0) ? m_reg[ix] : 32'h0;
      e_miss = spr_rd && ix < 0;
    end
    // save registers are written regardless of reset
    ix = idx_of(spr_num);
    if (spr_wr && ix >= 0) m_reg[ix] = (ix % 2 == 1) ? (spr_wdata & ~RSV) : spr_wdata;
    if (int_nc)   begin m_reg[0] = resume_pc; m_reg[1] = msr_cur; end
    if (int_crit) begin m_reg[2] = resume_pc; m_reg[3] = msr_cur; end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(e_tag, "redir_vld", {31'b0, redir_vld}, {31'b0, e_vld});
      chk(e_tag, "redir_pc", redir_pc, e_pc);
      chk(e_tag, "msr_ld", {31'b0, msr_ld}, {31'b0, e_ld});
      chk(e_tag, "msr_ld_data", msr_ld_data, e_ldd);
      chk("R8", "spr_rdata", spr_rdata, e_rd);
      chk("R8", "spr_miss", {31'b0, spr_miss}, {31'b0, e_miss});
    end
  end

  task automatic idle();
    int_nc = 0; int_crit = 0; ret_kind = 0; spr_wr = 0; spr_rd = 0;
  endtask

  task automatic wr(logic [9:0] n, logic [31:0] d);
    spr_wr = 1; spr_num = n; spr_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd_chk(string req, logic [9:0] n, logic [31:0] exp, logic miss);
    spr_rd = 1; spr_num = n;
    @(negedge clk); idle();
    chk(req, "read data", spr_rdata, exp);
    chk(req, "read miss", {31'b0, spr_miss}, {31'b0, miss});
  endtask

  task automatic ret(logic [1:0] k);
    ret_kind = k;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "redir_vld in reset", {31'b0, redir_vld}, 32'h0);
    chk("R10", "rdata in reset", spr_rdata, 32'h0);
    rst = 0; cmp_on = 1;
    wr(10'd26, 32'h0000_0100);
    wr(10'd27, 32'hFFFF_FFFF);
    wr(10'd58, 32'h0000_0200);
    wr(10'd59, 32'h1234_5F78);
    rd_chk("R7", 10'd27, 32'hFFFF_F0FF, 0);
    rd_chk("R7", 10'd58, 32'h0000_0200, 0);
    rd_chk("R8", 10'd99, 32'h0, 1);
    // R1 capture of full state including reserved bits
    resume_pc = 32'h0000_1000; msr_cur = 32'hFFFF_0F31; int_nc = 1;
    @(negedge clk); idle();
    rd_chk("R1", 10'd26, 32'h0000_1000, 0);
    rd_chk("R1", 10'd27, 32'hFFFF_0F31, 0);
    // R2 critical capture
    resume_pc = 32'h0000_2000; msr_cur = 32'h0000_8002; int_crit = 1;
    @(negedge clk); idle();
    rd_chk("R2", 10'd58, 32'h0000_2000, 0);
    rd_chk("R2", 10'd59, 32'h0000_8002, 0);
    // R3 non-critical return
    ret(2'd1);
    chk("R3", "redir pulse", {31'b0, redir_vld}, 32'h1);
    chk("R3", "redir pc", redir_pc, 32'h0000_1000);
    chk("R3", "msr data", msr_ld_data, 32'hFFFF_0F31);
    @(negedge clk);
    chk("R3", "pulse ends", {31'b0, redir_vld}, 32'h0);
    rd_chk("R6", 10'd58, 32'h0000_2000, 0);
    rd_chk("R6", 10'd59, 32'h0000_8002, 0);
    // R4 critical return
    ret(2'd2);
    chk("R4", "redir pc", redir_pc, 32'h0000_2000);
    chk("R4", "msr data", msr_ld_data, 32'h0000_8002);
    rd_chk("R6", 10'd26, 32'h0000_1000, 0);
    // R5 debug return
    ret(2'd3);
    chk("R5", "no redirect", {31'b0, redir_vld}, 32'h0);
    chk("R5", "no load", {31'b0, msr_ld}, 32'h0);
    rd_chk("R6", 10'd27, 32'hFFFF_0F31, 0);
    rd_chk("R6", 10'd59, 32'h0000_8002, 0);
    // R9 capture beats write
    resume_pc = 32'h0000_3000; msr_cur = 32'h0000_0055; int_nc = 1;
    spr_wr = 1; spr_num = 10'd26; spr_wdata = 32'hDEAD_BEEF;
    @(negedge clk); idle();
    rd_chk("R9", 10'd26, 32'h0000_3000, 0);
    // R10 reset keeps save registers
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    chk("R10", "redir after reset", {31'b0, redir_vld}, 32'h0);
    rd_chk("R10", 10'd26, 32'h0000_3000, 0);
    rd_chk("R10", 10'd59, 32'h0000_8002, 0);
    // back-to-back returns
    ret_kind = 2'd1; @(negedge clk); ret_kind = 2'd2; @(negedge clk); idle();
    chk("R4", "second redirect", redir_pc, 32'h0000_2000);
    // random traffic, model-compared every cycle
    for (int i = 0; i < 600; i++) begin
      int sel;
      int_nc    = ($urandom % 6) == 0;
      int_crit  = ($urandom % 6) == 0;
      resume_pc = $urandom;
      msr_cur   = $urandom;
      ret_kind  = 2'($urandom);
      spr_wr    = ($urandom % 3) == 0;
      spr_rd    = ($urandom % 2) == 0;
      sel = $urandom % 5;
      spr_num   = (sel == 0) ? 10'd26 : (sel == 1) ? 10'd27 :
                  (sel == 2) ? 10'd58 : (sel == 3) ? 10'd59 : 10'd99;
      spr_wdata = $urandom;
      rst       = ($urandom % 64) == 0;
      @(negedge clk);
    end
    idle(); rst = 0;
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule